// File: doc/BRIEF.md
# Indirect Register Window Access Gate

This block decides whether an access to one of the two indirect register windows may go ahead. One window belongs to supervisor level and the other to virtual-supervisor level. Each window holds a select register and six alias registers. The inputs are a 12-bit register address, the current privilege level and the virtualization bit. Two more inputs are the access-enable bits for this state: one from the machine enable register and one from the hypervisor enable register. The block is purely combinational, and its four outputs settle in the same cycle as its inputs.

An access that is allowed raises `acc_ok`. An access that is refused raises exactly one of two faults. The first is an illegal-instruction fault, which goes to the machine handler. The second is a virtual-instruction fault, which goes to the hypervisor. A guest running in virtual-supervisor mode uses the supervisor window addresses, and those accesses land on the virtual-supervisor registers. The `use_vs_window` output tells the register file which physical copy to use. The fault checks apply in a fixed order. The machine-level enable check comes first, then the virtual-instruction checks, and only then is the access allowed. A build parameter removes the hypervisor, and in that build the virtual-supervisor window becomes unreachable.

Top module: `csr_window_gate`

## Requirements
- R1: The supervisor window covers addresses 0x150 to 0x157 and the virtual-supervisor window covers 0x250 to 0x257. In both windows, offset 4 (0x154 and 0x254) is excluded. For an address outside both windows, `acc_ok`, `exc_illegal`, `exc_virtual` and `use_vs_window` are all 0.
- R2: Privilege levels are encoded on `priv_lvl` as follows: 3 is machine, 1 is supervisor, 0 is user, and 2 is treated as user. With `virt_mode`=1, supervisor becomes virtual-supervisor (VS) and user becomes virtual-user (VU). At machine level, `virt_mode` is ignored.
- R3: Machine mode is always allowed to reach both windows, whatever the enable bits. HS mode (supervisor with `virt_mode`=0) is allowed to reach both windows when `m_se60`=1. For allowed accesses, `use_vs_window` is 1 for virtual-supervisor addresses and 0 for supervisor addresses.
- R4: With `m_se60`=0, any window access from a mode other than machine raises `exc_illegal`.
- R5: A window access from user mode with `virt_mode`=0 raises `exc_illegal`.
- R6: With `m_se60`=1, an access from VS or VU mode to a virtual-supervisor address raises `exc_virtual`.
- R7: With `m_se60`=1, an access from VU mode to a supervisor address raises `exc_virtual`.
- R8: With `m_se60`=1 and `h_se60`=0, an access from VS mode to a supervisor address raises `exc_virtual`.
- R9: With both enable bits at 1, an access from VS mode to a supervisor address is allowed with `use_vs_window`=1.
- R10: For every input, at most one of `acc_ok`, `exc_illegal` and `exc_virtual` is 1. `use_vs_window` is 1 only together with `acc_ok`.
- R11: With `HYP_EN`=0, any virtual-supervisor address raises `exc_illegal` from every mode, machine included. In that build, `virt_mode` and `h_se60` have no effect, so supervisor level with `virt_mode`=1 behaves as HS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| csr_addr | input | 12 | Register address of the access |
| priv_lvl | input | 2 | Current privilege level (3 machine, 1 supervisor, 0/2 user) |
| virt_mode | input | 1 | Virtualization bit of the current mode |
| m_se60 | input | 1 | Machine access-enable bit for the indirect windows |
| h_se60 | input | 1 | Hypervisor access-enable bit for the supervisor window seen by guests |
| acc_ok | output | 1 | Access is allowed |
| exc_illegal | output | 1 | Access raises an illegal-instruction fault |
| exc_virtual | output | 1 | Access raises a virtual-instruction fault |
| use_vs_window | output | 1 | Allowed access targets the virtual-supervisor register copy |

## Verification
All four outputs are due in the same cycle as the inputs that produce them, because no register lies on any path. The driver changes the inputs just after a rising edge and pushes one expected item per cycle. The monitor pops that item at the following falling edge and compares it, by which time the logic has settled and the next change is still half a period away. A second instance built without the hypervisor sees the same inputs, and each item carries a separate expectation for it.

// File: rtl/csr_window_pkg.sv
package csr_window_pkg;

    localparam int CSR_ADDR_W = 12;
    localparam int NWIN       = 2;
    localparam int WIN_SUP    = 0;
    localparam int WIN_VSUP   = 1;

    localparam logic [1:0] PL_USER = 2'd0;
    localparam logic [1:0] PL_SUP  = 2'd1;
    localparam logic [1:0] PL_MACH = 2'd3;

    typedef enum logic [2:0] {
        MD_M,
        MD_HS,
        MD_U,
        MD_VS,
        MD_VU
    } mode_e;

    typedef struct packed {
        logic ok;
        logic illegal;
        logic virt_exc;
        logic to_vs;
    } verdict_t;

    function automatic logic is_guest(input mode_e m);
        return (m == MD_VS) || (m == MD_VU);
    endfunction

endpackage

// File: rtl/csr_win_decode.sv
module csr_win_decode
    import csr_window_pkg::*;
#(
    parameter int                  ADDR_W   = CSR_ADDR_W,
    parameter int                  SPAN_LG  = 3,
    parameter logic [ADDR_W-1:0]   BASE     = 12'h150,
    parameter int unsigned         HOLE_OFF = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    localparam logic [SPAN_LG-1:0] HOLE = HOLE_OFF[SPAN_LG-1:0];

    logic page_match;
    logic in_hole;

    always_comb begin
        page_match = (addr[ADDR_W-1:SPAN_LG] == BASE[ADDR_W-1:SPAN_LG]);
        in_hole    = (addr[SPAN_LG-1:0] == HOLE);
        hit        = page_match && !in_hole;
    end

endmodule

// File: rtl/csr_mode_classify.sv
module csr_mode_classify
    import csr_window_pkg::*;
#(
    parameter bit HYP_EN = 1'b1
) (
    input  logic [1:0] priv,
    input  logic       virt,
    output mode_e      mode
);

    logic guest;

    always_comb begin
        guest = HYP_EN && virt;
        case (priv)
            PL_MACH: mode = MD_M;
            PL_SUP:  mode = guest ? MD_VS : MD_HS;
            default: mode = guest ? MD_VU : MD_U;
        endcase
    end

endmodule

// File: rtl/csr_window_verdict.sv
module csr_window_verdict
    import csr_window_pkg::*;
#(
    parameter bit HYP_EN = 1'b1
) (
    input  mode_e     mode,
    input  logic      in_sup,
    input  logic      in_vsup,
    input  logic      m_se,
    input  logic      h_se,
    output verdict_t  vd
);

    logic any_hit;
    logic mach_block;
    logic guest_sup_ok;

    always_comb begin
        any_hit      = in_sup || in_vsup;
        mach_block   = (!HYP_EN && in_vsup) || (mode != MD_M && !m_se) || (mode == MD_U);
        guest_sup_ok = (mode == MD_VS) && in_sup && h_se;
        vd           = '0;
        if (any_hit) begin
            if (mach_block) begin
                vd.illegal = 1'b1;
            end else if (mode == MD_M || mode == MD_HS) begin
                vd.ok    = 1'b1;
                vd.to_vs = in_vsup;
            end else if (guest_sup_ok) begin
                vd.ok    = 1'b1;
                vd.to_vs = 1'b1;
            end else if (is_guest(mode)) begin
                vd.virt_exc = 1'b1;
            end
        end
    end

endmodule

// File: rtl/csr_window_gate.sv
module csr_window_gate
    import csr_window_pkg::*;
#(
    parameter int                ADDR_W   = CSR_ADDR_W,
    parameter bit                HYP_EN   = 1'b1,
    parameter int                SPAN_LG  = 3,
    parameter logic [ADDR_W-1:0] SUP_BASE = 12'h150,
    parameter logic [ADDR_W-1:0] VS_BASE  = 12'h250,
    parameter int unsigned       HOLE_OFF = 4
) (
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [1:0]        priv_lvl,
    input  logic              virt_mode,
    input  logic              m_se60,
    input  logic              h_se60,
    output logic              acc_ok,
    output logic              exc_illegal,
    output logic              exc_virtual,
    output logic              use_vs_window
);

    logic [NWIN-1:0] win_hit;
    mode_e           cur_mode;
    verdict_t        verdict;

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        csr_win_decode #(
            .ADDR_W   (ADDR_W),
            .SPAN_LG  (SPAN_LG),
            .BASE     ((g == WIN_SUP) ? SUP_BASE : VS_BASE),
            .HOLE_OFF (HOLE_OFF)
        ) u_dec (
            .addr (csr_addr),
            .hit  (win_hit[g])
        );
    end

    csr_mode_classify #(
        .HYP_EN (HYP_EN)
    ) u_mode (
        .priv (priv_lvl),
        .virt (virt_mode),
        .mode (cur_mode)
    );

    csr_window_verdict #(
        .HYP_EN (HYP_EN)
    ) u_verdict (
        .mode    (cur_mode),
        .in_sup  (win_hit[WIN_SUP]),
        .in_vsup (win_hit[WIN_VSUP]),
        .m_se    (m_se60),
        .h_se    (h_se60),
        .vd      (verdict)
    );

    always_comb begin
        acc_ok        = verdict.ok;
        exc_illegal   = verdict.illegal;
        exc_virtual   = verdict.virt_exc;
        use_vs_window = verdict.to_vs;
    end

endmodule

// File: rtl/csr_window_gate_chk.sv
module csr_window_gate_chk #(
    parameter bit HYP_EN = 1'b1
) (
    input logic [1:0] priv_lvl,
    input logic       virt_mode,
    input logic       m_se60,
    input logic       acc_ok,
    input logic       exc_illegal,
    input logic       exc_virtual,
    input logic       use_vs_window,
    input logic [1:0] win_hit
);

    logic any_out;

    always_comb begin
        any_out = acc_ok | exc_illegal | exc_virtual;

        a_r10_one_verdict: assert ($onehot0({acc_ok, exc_illegal, exc_virtual}))
            else $error("R10: more than one verdict raised");

        a_r10_redirect_needs_ok: assert (!use_vs_window || acc_ok)
            else $error("R10: window redirect without an allowed access");

        a_r1_outside_quiet: assert ((|win_hit) || !any_out)
            else $error("R1: verdict raised for an address outside both windows");

        a_r1_inside_decided: assert (!(|win_hit) || any_out)
            else $error("R1: window address left without a verdict");

        if ((|win_hit) && priv_lvl != 2'd3 && !m_se60) begin
            a_r4_machine_gate: assert (exc_illegal)
                else $error("R4: cleared machine enable did not fault");
        end

        if (HYP_EN && (|win_hit) && priv_lvl == 2'd3) begin
            a_r3_machine_allowed: assert (acc_ok)
                else $error("R3: machine access refused");
        end

        if (HYP_EN && win_hit[1] && virt_mode && priv_lvl != 2'd3 && m_se60) begin
            a_r6_guest_vs_window: assert (exc_virtual)
                else $error("R6: guest reached the virtual-supervisor window");
        end

        if (!HYP_EN && win_hit[1]) begin
            a_r11_no_hyp_vs_window: assert (exc_illegal)
                else $error("R11: virtual-supervisor address usable without hypervisor");
        end
    end

endmodule

bind csr_window_gate csr_window_gate_chk #(
    .HYP_EN (HYP_EN)
) u_chk (
    .priv_lvl      (priv_lvl),
    .virt_mode     (virt_mode),
    .m_se60        (m_se60),
    .acc_ok        (acc_ok),
    .exc_illegal   (exc_illegal),
    .exc_virtual   (exc_virtual),
    .use_vs_window (use_vs_window),
    .win_hit       (win_hit)
);

// File: tb/csr_window_gate_tb.sv
module csr_window_gate_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] a;
    logic [1:0]  pr;
    logic        vi, ms, hs;
    logic        h_ok, h_ill, h_vex, h_tvs;
    logic        n_ok, n_ill, n_vex, n_tvs;
    int          total = 0;
    int          bad   = 0;
    bit          done  = 1'b0;

    typedef struct {
        logic [11:0] a;
        logic [1:0]  pr;
        logic        vi, ms, hs;
        logic [3:0]  e_h;
        logic [3:0]  e_n;
        string       tag;
    } item_t;

    item_t q[$];

    always #10 clk = ~clk;

    csr_window_gate u_dut (
        .csr_addr (a), .priv_lvl (pr), .virt_mode (vi), .m_se60 (ms), .h_se60 (hs),
        .acc_ok (h_ok), .exc_illegal (h_ill), .exc_virtual (h_vex), .use_vs_window (h_tvs)
    );

    csr_window_gate #(.HYP_EN (1'b0)) u_nohyp (
        .csr_addr (a), .priv_lvl (pr), .virt_mode (vi), .m_se60 (ms), .h_se60 (hs),
        .acc_ok (n_ok), .exc_illegal (n_ill), .exc_virtual (n_vex), .use_vs_window (n_tvs)
    );

    // Expected {ok, illegal, virtual, to_vs} from the requirements.
    function automatic logic [3:0] model(input logic [11:0] ad, input logic [1:0] p,
                                         input logic v, input logic me, input logic he,
                                         input bit hyp);
        logic s_win, v_win, g;
        s_win = (ad[11:3] == 9'h02A) && (ad[2:0] != 3'd4);
        v_win = (ad[11:3] == 9'h04A) && (ad[2:0] != 3'd4);
        g     = hyp && v;
        if (!s_win && !v_win)  return 4'b0000;          // R1
        if (!hyp && v_win)     return 4'b0100;          // R11
        if (p == 2'd3)         return {3'b100, v_win};  // R3
        if (!me)               return 4'b0100;          // R4
        if (p != 2'd1 && !g)   return 4'b0100;          // R5
        if (p == 2'd1 && !g)   return {3'b100, v_win};  // R3
        if (v_win)             return 4'b0010;          // R6
        if (p != 2'd1)         return 4'b0010;          // R7
        if (!he)               return 4'b0010;          // R8
        return 4'b1001;                                 // R9
    endfunction

    task automatic drive(input logic [11:0] ad, input logic [1:0] p, input logic v,
                         input logic me, input logic he, input string tag);
        item_t it;
        @(posedge clk);
        a = ad; pr = p; vi = v; ms = me; hs = he;
        it.a = ad; it.pr = p; it.vi = v; it.ms = me; it.hs = he;
        it.e_h = model(ad, p, v, me, he, 1'b1);
        it.e_n = model(ad, p, v, me, he, 1'b0);
        it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: outputs are combinational, so each item is due at the next falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                total++;
                if ({h_ok, h_ill, h_vex, h_tvs} !== it.e_h) begin
                    bad++;
                    $display("FAIL %s hyp addr=%h priv=%0d virt=%0b mse=%0b hse=%0b actual=%b expected=%b",
                             it.tag, it.a, it.pr, it.vi, it.ms, it.hs,
                             {h_ok, h_ill, h_vex, h_tvs}, it.e_h);
                end
                total++;
                if ({n_ok, n_ill, n_vex, n_tvs} !== it.e_n) begin
                    bad++;
                    $display("FAIL %s nohyp addr=%h priv=%0d virt=%0b mse=%0b hse=%0b actual=%b expected=%b",
                             it.tag, it.a, it.pr, it.vi, it.ms, it.hs,
                             {n_ok, n_ill, n_vex, n_tvs}, it.e_n);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        a = 12'h000; pr = 2'd0; vi = 1'b0; ms = 1'b0; hs = 1'b0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        drive(12'h000, 2'd0, 1'b0, 1'b0, 1'b0, "R1 reset");

        drive(12'h154, 2'd3, 1'b0, 1'b1, 1'b1, "R1");
        drive(12'h158, 2'd3, 1'b0, 1'b1, 1'b1, "R1");
        drive(12'h14F, 2'd1, 1'b0, 1'b1, 1'b1, "R1");
        drive(12'h254, 2'd3, 1'b0, 1'b1, 1'b1, "R1");
        drive(12'h157, 2'd3, 1'b0, 1'b1, 1'b1, "R1");
        drive(12'h150, 2'd2, 1'b0, 1'b1, 1'b1, "R2");
        drive(12'h250, 2'd3, 1'b1, 1'b0, 1'b0, "R2");
        drive(12'h151, 2'd1, 1'b0, 1'b1, 1'b0, "R3");
        drive(12'h256, 2'd1, 1'b0, 1'b1, 1'b0, "R3");
        drive(12'h250, 2'd3, 1'b0, 1'b0, 1'b0, "R3");
        drive(12'h150, 2'd1, 1'b0, 1'b0, 1'b1, "R4");
        drive(12'h150, 2'd1, 1'b1, 1'b0, 1'b1, "R4");
        drive(12'h250, 2'd0, 1'b1, 1'b0, 1'b1, "R4");
        drive(12'h152, 2'd0, 1'b0, 1'b1, 1'b1, "R5");
        drive(12'h253, 2'd1, 1'b1, 1'b1, 1'b1, "R6");
        drive(12'h250, 2'd0, 1'b1, 1'b1, 1'b1, "R6");
        drive(12'h150, 2'd0, 1'b1, 1'b1, 1'b1, "R7");
        drive(12'h155, 2'd1, 1'b1, 1'b1, 1'b0, "R8");
        drive(12'h157, 2'd1, 1'b1, 1'b1, 1'b1, "R9");
        drive(12'h257, 2'd3, 1'b0, 1'b1, 1'b1, "R11");
        drive(12'h150, 2'd1, 1'b1, 1'b1, 1'b0, "R11");

        for (int base = 0; base < 2; base++) begin
            for (int off = 0; off < 12; off++) begin
                for (int k = 0; k < 32; k++) begin
                    logic [11:0] ad;
                    ad = (base == 0 ? 12'h14E : 12'h24E) + 12'(off);
                    drive(ad, k[1:0], k[2], k[3], k[4], "R10");
                end
            end
        end

        while (q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule